// File: doc/BRIEF.md
# Configurable Sum-of-Products Arithmetic Unit

This block is a purely combinational multiply-accumulate datapath whose shape is fixed when it is elaborated. A single packed bit-string parameter lists a number of terms. For each term it gives the widths of two operands, whether the term is treated as signed, and whether it is added to or taken away from the total. Every operand of every term arrives on one wide operand bus, packed end to end with no gaps. A second, narrow bus carries single-bit addends, each of which adds one when set.

The output is the sum over all terms plus the number of set addend bits, reduced modulo two to the power of the result width. A term with an empty second operand passes its first operand through (extended) instead of forming a product. A term with both operands empty contributes nothing and takes no bits from the bus. An inconsistent configuration string, or an operand bus whose width does not match the configured sizes, stops elaboration with a message.

Top module: `macc_sop`

## Requirements
- R1: The configuration begins with a 4-bit field, least significant bit first, holding N, the number of bits in every size field. Each term descriptor then holds, from its lowest bit upward, a signed flag, a subtract flag, the first-operand size (N bits, LSB first) and the second-operand size (N bits, LSB first).
- R2: Operands are taken from the operand bus starting at bit 0 in descriptor order; a term's first operand sits directly below its second, and the next term's operands follow with no gap.
- R3: When a term's signed flag is 1, both of its operands are sign-extended to the result width; when it is 0, both are zero-extended.
- R4: A term whose subtract flag is 1 is subtracted from the total; otherwise it is added.
- R5: A term whose second-operand size is 0 contributes its first operand alone, extended to the result width per R3, instead of a product.
- R6: A descriptor with both sizes 0 contributes nothing and consumes no operand-bus bits.
- R7: Each set bit of the addend bus adds exactly one to the total; clear bits add nothing.
- R8: All arithmetic is performed at the result width; overflow wraps modulo 2 to the power of the result width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | OPB_W | All term operands packed end to end, first term at bit 0 |
| bits | input | BIT_W | Single-bit unsigned addends |
| result | output | RES_W | Wrapped sum of all terms and addend bits |

## Verification
The bench builds the block twice. The default build uses 4-bit size fields and a 16-bit result, with a signed 8x8 product, a subtracted unsigned 6x5 product, a signed 7-bit pass-through, an empty descriptor and a small unsigned product, so that mixed signedness, the empty term's effect on operand positions, and pass-through sign extension can all be reached. The second build uses 3-bit size fields and an 8-bit result, with a subtracted signed product wider than the output and a subtracted unsigned pass-through, which brings wraparound and negation of extended operands within reach under both directed extremes and random operands.

// File: rtl/macc_sop_pkg.sv
`timescale 1ns/1ps
package macc_sop_pkg;

    // Widest configuration string the decode functions accept.
    localparam int CFG_MAX = 512;

    // Unsigned field of n bits starting at lo, least significant bit first.
    function automatic int cfg_field(logic [CFG_MAX-1:0] c, int lo, int n);
        int v;
        v = 0;
        for (int i = 0; i < n; i++) begin
            if (c[lo + i]) v = v | (1 << i);
        end
        return v;
    endfunction

    // Header: width of every size field.
    function automatic int size_bits(logic [CFG_MAX-1:0] c);
        return cfg_field(c, 0, 4);
    endfunction

    // Width of one term descriptor.
    function automatic int desc_width(logic [CFG_MAX-1:0] c);
        return 2 + 2 * size_bits(c);
    endfunction

    function automatic int term_count(logic [CFG_MAX-1:0] c, int cw);
        return (cw - 4) / desc_width(c);
    endfunction

    function automatic int desc_lo(logic [CFG_MAX-1:0] c, int k);
        return 4 + k * desc_width(c);
    endfunction

    function automatic bit term_signed(logic [CFG_MAX-1:0] c, int k);
        return c[desc_lo(c, k)];
    endfunction

    function automatic bit term_sub(logic [CFG_MAX-1:0] c, int k);
        return c[desc_lo(c, k) + 1];
    endfunction

    function automatic int term_size_a(logic [CFG_MAX-1:0] c, int k);
        return cfg_field(c, desc_lo(c, k) + 2, size_bits(c));
    endfunction

    function automatic int term_size_b(logic [CFG_MAX-1:0] c, int k);
        return cfg_field(c, desc_lo(c, k) + 2 + size_bits(c), size_bits(c));
    endfunction

    // Bus position of term k's first operand.
    function automatic int term_offset(logic [CFG_MAX-1:0] c, int k);
        int off;
        off = 0;
        for (int j = 0; j < k; j++) begin
            off = off + term_size_a(c, j) + term_size_b(c, j);
        end
        return off;
    endfunction

    // Consistency of string length, header and bus width.
    function automatic bit cfg_consistent(logic [CFG_MAX-1:0] c, int cw, int opw);
        if (cw < 4 || cw > CFG_MAX) return 1'b0;
        if (((cw - 4) % desc_width(c)) != 0) return 1'b0;
        if (term_offset(c, term_count(c, cw)) != opw) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/macc_ext.sv
`timescale 1ns/1ps
// Extends (or truncates) one operand to the result width.
module macc_ext #(
    parameter int IN_W      = 8,
    parameter bit USED      = 1'b1,
    parameter bit IS_SIGNED = 1'b0,
    parameter int RES_W     = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [RES_W-1:0] dout
);
    logic unused_din;
    assign unused_din = ^din;

    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        if (!USED) begin : g_none
            assign dout[i] = 1'b0;
        end else if (i < IN_W) begin : g_copy
            assign dout[i] = din[i];
        end else if (IS_SIGNED) begin : g_sext
            assign dout[i] = din[IN_W-1];
        end else begin : g_zext
            assign dout[i] = 1'b0;
        end
    end
endmodule

// File: rtl/macc_term.sv
`timescale 1ns/1ps
// One configured term: extended product or pass-through, optionally negated.
module macc_term #(
    parameter int A_W       = 8,
    parameter int B_W       = 8,
    parameter bit IS_SIGNED = 1'b0,
    parameter bit IS_SUB    = 1'b0,
    parameter int RES_W     = 16,
    localparam int AW_P     = (A_W > 0) ? A_W : 1,
    localparam int BW_P     = (B_W > 0) ? B_W : 1
) (
    input  logic [AW_P-1:0]  opa,
    input  logic [BW_P-1:0]  opb,
    output logic [RES_W-1:0] value
);
    logic [RES_W-1:0] ext_a;
    logic [RES_W-1:0] prod_d;
    logic [RES_W-1:0] value_d;

    macc_ext #(
        .IN_W(AW_P), .USED(A_W > 0), .IS_SIGNED(IS_SIGNED), .RES_W(RES_W)
    ) u_ext_a (
        .din(opa), .dout(ext_a)
    );

    if (B_W == 0) begin : g_pass
        logic unused_opb;
        assign unused_opb = ^opb;
        assign prod_d = ext_a;
    end else begin : g_mul
        logic [RES_W-1:0] ext_b;
        macc_ext #(
            .IN_W(BW_P), .USED(1'b1), .IS_SIGNED(IS_SIGNED), .RES_W(RES_W)
        ) u_ext_b (
            .din(opb), .dout(ext_b)
        );
        // Low RES_W bits of the product of extended operands are exact mod 2^RES_W.
        assign prod_d = ext_a * ext_b;
    end

    always_comb begin
        if (IS_SUB) value_d = '0 - prod_d;
        else        value_d = prod_d;
    end

    assign value = value_d;
endmodule

// File: rtl/macc_popcount.sv
`timescale 1ns/1ps
// Counts set addend bits at the result width.
module macc_popcount #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] count
);
    logic [OUT_W-1:0] count_d;

    always_comb begin
        count_d = '0;
        for (int i = 0; i < IN_W; i++) begin
            count_d = count_d + OUT_W'(din[i]);
        end
    end

    assign count = count_d;
endmodule

// File: rtl/macc_sop.sv
`timescale 1ns/1ps
module macc_sop
    import macc_sop_pkg::*;
#(
    parameter int CFG_W = 54,
    parameter logic [CFG_W-1:0] CFG = {
        4'd3, 4'd4, 1'b0, 1'b0,   // term 4: unsigned add, 4x3
        4'd0, 4'd0, 1'b0, 1'b0,   // term 3: empty
        4'd0, 4'd7, 1'b0, 1'b1,   // term 2: signed add, 7-bit pass-through
        4'd5, 4'd6, 1'b1, 1'b0,   // term 1: unsigned subtract, 6x5
        4'd8, 4'd8, 1'b0, 1'b1,   // term 0: signed add, 8x8
        4'd4                      // size fields are 4 bits wide
    },
    parameter int OPB_W = 41,
    parameter int BIT_W = 5,
    parameter int RES_W = 16
) (
    input  logic [OPB_W-1:0] opnd,
    input  logic [BIT_W-1:0] bits,
    output logic [RES_W-1:0] result
);
    localparam logic [CFG_MAX-1:0] CFG_X = CFG_MAX'(CFG);
    localparam int NT   = term_count(CFG_X, CFG_W);
    localparam int NT_P = (NT > 0) ? NT : 1;

    if (!cfg_consistent(CFG_X, CFG_W, OPB_W)) begin : g_bad_cfg
        $error("macc_sop: configuration length, header or operand bus width OPB_W=%0d is inconsistent", OPB_W);
    end

    logic [NT_P-1:0][RES_W-1:0] term_val;
    logic [RES_W-1:0]           ones_cnt;
    logic [RES_W-1:0]           acc_d;

    if (NT == 0) begin : g_no_terms
        assign term_val = '0;
    end

    for (genvar k = 0; k < NT; k++) begin : g_term
        localparam int  SA   = term_size_a(CFG_X, k);
        localparam int  SB   = term_size_b(CFG_X, k);
        localparam int  OFF  = term_offset(CFG_X, k);
        localparam bit  SGN  = term_signed(CFG_X, k);
        localparam bit  NEG  = term_sub(CFG_X, k);
        localparam int  SA_P = (SA > 0) ? SA : 1;
        localparam int  SB_P = (SB > 0) ? SB : 1;

        logic [SA_P-1:0] a_k;
        logic [SB_P-1:0] b_k;

        if (SA > 0) begin : g_a
            assign a_k = opnd[OFF +: SA_P];
        end else begin : g_a0
            assign a_k = '0;
        end

        if (SB > 0) begin : g_b
            assign b_k = opnd[OFF + SA +: SB_P];
        end else begin : g_b0
            assign b_k = '0;
        end

        macc_term #(
            .A_W(SA), .B_W(SB), .IS_SIGNED(SGN), .IS_SUB(NEG), .RES_W(RES_W)
        ) u_term (
            .opa(a_k), .opb(b_k), .value(term_val[k])
        );
    end

    macc_popcount #(.IN_W(BIT_W), .OUT_W(RES_W)) u_ones (
        .din(bits), .count(ones_cnt)
    );

    always_comb begin
        acc_d = ones_cnt;
        for (int k = 0; k < NT_P; k++) begin
            acc_d = acc_d + term_val[k];
        end
    end

    assign result = acc_d;
endmodule

// File: rtl/macc_sop_chk.sv
`timescale 1ns/1ps
module macc_sop_chk
    import macc_sop_pkg::*;
#(
    parameter int CFG_W = 54,
    parameter logic [CFG_W-1:0] CFG = '0,
    parameter int OPB_W = 41,
    parameter int BIT_W = 5,
    parameter int RES_W = 16,
    localparam logic [CFG_MAX-1:0] CFG_X = CFG_MAX'(CFG),
    localparam int NT   = term_count(CFG_X, CFG_W),
    localparam int NT_P = (NT > 0) ? NT : 1
) (
    input logic [OPB_W-1:0]            opnd,
    input logic [BIT_W-1:0]            bits,
    input logic [RES_W-1:0]            result,
    input logic [NT_P-1:0][RES_W-1:0]  term_val,
    input logic [RES_W-1:0]            ones_cnt
);
    logic unused_res;
    assign unused_res = ^result;

    always_comb begin
        assert_ones_match_R7: assert (ones_cnt == RES_W'($countones(bits)))
            else $error("R7: addend count %0d differs from set bits", ones_cnt);
        assert_ones_range_R7: assert (32'(ones_cnt) <= BIT_W || RES_W < 32)
            else $error("R7: addend count %0d exceeds bus width", ones_cnt);
    end

    for (genvar k = 0; k < NT; k++) begin : g_chk
        localparam int SA  = term_size_a(CFG_X, k);
        localparam int SB  = term_size_b(CFG_X, k);
        localparam int OFF = term_offset(CFG_X, k);
        localparam bit SGN = term_signed(CFG_X, k);
        localparam bit NEG = term_sub(CFG_X, k);

        if (SA > 0 && SB == 0) begin : g_pass
            logic [RES_W-1:0] want;
            always_comb begin
                want = '0;
                for (int i = 0; i < RES_W; i++) begin
                    if (i < SA) want[i] = opnd[OFF + i];
                    else        want[i] = SGN ? opnd[OFF + SA - 1] : 1'b0;
                end
                if (NEG) want = '0 - want;
                // R5 pass-through, R3 extension, R4 direction
                assert_single_operand_R5: assert (term_val[k] == want)
                    else $error("R5: term %0d value %h, expected %h", k, term_val[k], want);
            end
        end

        if (SA > 0 && SB > 0) begin : g_prod
            always_comb begin
                assert_zero_factor_R4: assert (opnd[OFF +: SA] != '0 || term_val[k] == '0)
                    else $error("R4: term %0d nonzero with zero first operand", k);
            end
        end
    end
endmodule

bind macc_sop macc_sop_chk #(
    .CFG_W(CFG_W), .CFG(CFG), .OPB_W(OPB_W), .BIT_W(BIT_W), .RES_W(RES_W)
) u_chk (
    .opnd(opnd), .bits(bits), .result(result),
    .term_val(term_val), .ones_cnt(ones_cnt)
);

// File: tb/macc_sop_test.sv
`timescale 1ns/1ps
module macc_sop_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Build A: default configuration, 16-bit result.
    logic [40:0] opA;
    logic [4:0]  bitsA;
    logic [15:0] resA;
    macc_sop uut (.opnd(opA), .bits(bitsA), .result(resA));

    // Build B: 3-bit size fields, 8-bit result.
    // term0 signed subtract 7x6, term1 unsigned subtract 5-bit pass, term2 signed add 3x2
    logic [22:0] opB;
    logic [2:0]  bitsB;
    logic [7:0]  resB;
    macc_sop #(
        .CFG_W(28),
        .CFG({3'd2, 3'd3, 1'b0, 1'b1,
              3'd0, 3'd5, 1'b1, 1'b0,
              3'd6, 3'd7, 1'b1, 1'b1,
              4'd3}),
        .OPB_W(23), .BIT_W(3), .RES_W(8)
    ) uut_b (.opnd(opB), .bits(bitsB), .result(resB));

    function automatic longint sx(longint v, int w);
        longint half = longint'(1) << (w - 1);
        return (v >= half) ? v - (longint'(1) << w) : v;
    endfunction

    function automatic longint refA(longint a0, longint b0, longint a1, longint b1,
                                    longint a2, longint a4, longint b4, logic [4:0] bb);
        longint s;
        s = sx(a0, 8) * sx(b0, 8) - a1 * b1 + sx(a2, 7) + a4 * b4 + longint'($countones(bb));
        return s & 64'hFFFF;
    endfunction

    function automatic longint refB(longint a0, longint b0, longint a1,
                                    longint a2, longint b2, logic [2:0] bb);
        longint s;
        s = -(sx(a0, 7) * sx(b0, 6)) - a1 + sx(a2, 3) * sx(b2, 2) + longint'($countones(bb));
        return s & 64'hFF;
    endfunction

    task automatic chk(string req, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Field order on bus A: a0[7:0] b0[15:8] a1[21:16] b1[26:22] a2[33:27] a4[37:34] b4[40:38]
    task automatic runA(string req, logic [7:0] a0, logic [7:0] b0, logic [5:0] a1,
                        logic [4:0] b1, logic [6:0] a2, logic [3:0] a4, logic [2:0] b4,
                        logic [4:0] bb);
        @(negedge clk);
        opA = {b4, a4, a2, b1, a1, b0, a0};
        bitsA = bb;
        #1;
        chk(req, longint'(resA), refA(a0, b0, a1, b1, a2, a4, b4, bb));
    endtask

    // Field order on bus B: a0[6:0] b0[12:7] a1[17:13] a2[20:18] b2[22:21]
    task automatic runB(string req, logic [6:0] a0, logic [5:0] b0, logic [4:0] a1,
                        logic [2:0] a2, logic [1:0] b2, logic [2:0] bb);
        @(negedge clk);
        opB = {b2, a2, a1, b0, a0};
        bitsB = bb;
        #1;
        chk(req, longint'(resB), refB(a0, b0, a1, a2, b2, bb));
    endtask

    task automatic t_idle();
        @(negedge clk);
        opA = '0; bitsA = '0; opB = '0; bitsB = '0;
        #1;
        chk("R6 idle A", longint'(resA), 0);
        chk("R6 idle B", longint'(resB), 0);
    endtask

    task automatic t_layout();
        @(negedge clk);
        opA = {3'd0, 4'd0, 7'd0, 5'd0, 6'd0, 8'd5, 8'd3};
        bitsA = '0;
        #1;
        chk("R1 R2 term0 3*5", longint'(resA), 64'h000F);
        runA("R2 term1 fields", 8'd0, 8'd0, 6'd2, 5'd3, 7'd0, 4'd0, 3'd0, 5'd0);
        @(negedge clk);
        opA = {3'd7, 4'd15, 7'd0, 5'd0, 6'd0, 8'd0, 8'd0};
        #1;
        chk("R2 R6 last term after empty descriptor", longint'(resA), 64'd105);
    endtask

    task automatic t_sign();
        @(negedge clk);
        opA = {3'd0, 4'd0, 7'd0, 5'd0, 6'd0, 8'h80, 8'h80};
        bitsA = '0;
        #1;
        chk("R3 signed -128*-128", longint'(resA), 64'h4000);
        runA("R3 signed -1*2", 8'hFF, 8'd2, 6'd0, 5'd0, 7'd0, 4'd0, 3'd0, 5'd0);
        @(negedge clk);
        opA = {3'd0, 4'd0, 7'h7F, 5'd0, 6'd0, 8'd0, 8'd0};
        #1;
        chk("R3 R5 signed pass-through -1", longint'(resA), 64'hFFFF);
        runB("R3 narrow signed product", 7'h7F, 6'h3F, 5'd0, 3'd7, 2'd3, 3'd0);
    endtask

    task automatic t_subtract();
        @(negedge clk);
        opA = {3'd0, 4'd0, 7'd0, 5'd31, 6'd63, 8'd0, 8'd0};
        bitsA = '0;
        #1;
        chk("R4 unsigned subtract 63*31", longint'(resA), 64'hF85F);
        @(negedge clk);
        opB = {2'd0, 3'd0, 5'd5, 6'd0, 7'd0};
        bitsB = '0;
        #1;
        chk("R4 R5 subtracted pass-through", longint'(resB), 64'hFB);
        runB("R4 signed subtract", 7'd3, 6'd4, 5'd0, 3'd0, 2'd0, 3'd0);
    endtask

    task automatic t_addends();
        @(negedge clk);
        opA = '0;
        bitsA = 5'b10110;
        #1;
        chk("R7 three addend bits", longint'(resA), 64'd3);
        @(negedge clk);
        bitsA = 5'b11111;
        #1;
        chk("R7 all addend bits", longint'(resA), 64'd5);
        runB("R7 addends with term", 7'd1, 6'd1, 5'd0, 3'd0, 2'd0, 3'b101);
    endtask

    task automatic t_wrap();
        @(negedge clk);
        opB = {2'd0, 3'd0, 5'd0, 6'h20, 7'h40};
        bitsB = '0;
        #1;
        chk("R8 wrap -64*-32 negated", longint'(resB), 64'h00);
        runB("R8 wrap mixed", 7'h3F, 6'h1F, 5'd31, 3'd3, 2'd1, 3'b111);
        runA("R8 wrap wide", 8'h7F, 8'h7F, 6'd63, 5'd31, 7'h3F, 4'd15, 3'd7, 5'b11111);
    endtask

    task automatic t_random();
        for (int i = 0; i < 150; i++) begin
            runA("R1-mix random A", 8'($urandom), 8'($urandom), 6'($urandom), 5'($urandom),
                 7'($urandom), 4'($urandom), 3'($urandom), 5'($urandom));
            runB("R8 random B", 7'($urandom), 6'($urandom), 5'($urandom),
                 3'($urandom), 2'($urandom), 3'($urandom));
        end
    endtask

    initial begin
        opA = '0; bitsA = '0; opB = '0; bitsB = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_layout();
        t_sign();
        t_subtract();
        t_addends();
        t_wrap();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule